// File: doc/BRIEF.md
# Serial BCD Digit Validity Checker

This block watches a serial bit stream and sorts each 4-bit code into a valid decimal digit or a code that is not allowed. Every four accepted bits make up one value N. The first bit of a group has weight 1, the second weight 2, the third weight 4 and the fourth weight 8. When the fourth bit arrives, the block reports whether N lies in 0..9, which is a legal BCD digit, or in 10..15, which is an illegal code. It does not keep the whole nibble. A six-state Mealy graph records only the position within the group and whether the bit of weight 2 or the bit of weight 4 has been 1. That is sufficient, because N is at least 10 exactly when the weight-8 bit is 1 and at least one of those two middle bits is also 1.

An upstream deserializer or line receiver drives `bit_in` together with the qualifier `bit_valid`. On a clock edge where `bit_valid` is low, nothing is consumed. The verdict arrives on registered outputs one cycle after the edge that consumes the fourth bit. A strobe marks that cycle. A synchronous reset brings the machine back to the start of a group.

The states are as follows:
- `ST_POS0`: waiting for the weight-1 bit.
- `ST_POS1`: waiting for the weight-2 bit. The weight-1 bit cannot affect the verdict, so both of its values lead here.
- `ST_POS2_CLR` and `ST_POS2_SET`: waiting for the weight-4 bit, after a weight-2 bit of 0 or 1 respectively.
- `ST_POS3_CLR` and `ST_POS3_SET`: waiting for the weight-8 bit. `ST_POS3_SET` means that at least one middle bit was 1.

The transitions are as follows:
- take-b0: `ST_POS0` to `ST_POS1`.
- take-b1: `ST_POS1` to `ST_POS2_CLR` if the bit is 0, or to `ST_POS2_SET` if it is 1.
- take-b2: from `ST_POS2_CLR` to `ST_POS3_CLR` if the bit is 0, otherwise to `ST_POS3_SET`. From `ST_POS2_SET` always to `ST_POS3_SET`.
- close: any `ST_POS3_*` to `ST_POS0`, raising the strobe. The verdict is 1 only when leaving `ST_POS3_SET` with a bit of 1.
- hold: no change while `bit_valid` is low.

Top module: `serial_bcd_checker`

## Requirements
- R1: When `rst` is high at a clock edge, both `digit_strobe` and `digit_bad` are 0 in the following cycle, and the next accepted bit is taken as the weight-1 bit of a new group.
- R2: Four consecutive accepted bits form one value N, least significant bit first: N = b0 + 2·b1 + 4·b2 + 8·b3.
- R3: `digit_strobe` is 1 for exactly the one cycle after the edge that consumes the fourth bit of a group, and 0 in every other cycle.
- R4: In a strobe cycle, `digit_bad` is 0 when N is in 0..9.
- R5: In a strobe cycle, `digit_bad` is 1 when N is in 10..15.
- R6: `digit_bad` is 0 in every cycle in which `digit_strobe` is 0, which includes the cycles after the first three bits of a group.
- R7: An edge with `bit_valid` low consumes nothing and does not change the position in the group, whatever the value of `bit_in`. The outputs are 0 in the following cycle.
- R8: After the fourth bit, the machine is back in its initial state, so groups can follow each other with no idle cycle between them.
- R9: A reset in the middle of a group discards the partial group, and the next group is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Qualifies `bit_in` on this edge |
| bit_in | input | 1 | Serial data, least significant bit of each group first |
| digit_bad | output | 1 | 1 when the group just closed holds a value of 10..15 |
| digit_strobe | output | 1 | One-cycle marker of a closed group |

## Verification
Several properties are checked on every cycle. A verdict of 1 is only allowed together with the strobe, and only when it is preceded by `ST_POS3_SET` and an accepted bit of 1. Two strobes never occur on adjacent cycles. A strobe always leaves the machine in `ST_POS0`. An idle edge leaves the state unchanged. Reset clears both outputs. The bench shows what these local checks cannot: that all sixteen codes are sorted correctly in the LSB-first order. It does so for back-to-back groups, for groups broken up by idle cycles in which `bit_in` toggles, and after resets that cut a group short. Each case is compared against an independent model that builds the nibble and tests N > 9.

// File: rtl/bcdchk_pkg.sv
`timescale 1ns/1ps
package bcdchk_pkg;

    // number of serial bits that make up one digit code
    localparam int GROUP_LEN   = 4;
    localparam int STATE_W     = 3;

    // position within the group, plus "a middle bit was 1" where it matters
    typedef enum logic [STATE_W-1:0] {
        ST_POS0     = 3'd0,
        ST_POS1     = 3'd1,
        ST_POS2_CLR = 3'd2,
        ST_POS2_SET = 3'd3,
        ST_POS3_CLR = 3'd4,
        ST_POS3_SET = 3'd5
    } chk_state_t;

endpackage

// File: rtl/bcdchk_next.sv
`timescale 1ns/1ps
module bcdchk_next
    import bcdchk_pkg::*;
(
    input  chk_state_t cur_state,
    input  logic       bit_valid,
    input  logic       bit_in,
    output chk_state_t nxt_state,
    output logic       group_done,
    output logic       group_bad
);

    always_comb begin
        nxt_state  = cur_state;
        group_done = 1'b0;
        group_bad  = 1'b0;
        if (bit_valid) begin
            unique case (cur_state)
                // take-b0: weight-1 bit never influences the verdict
                ST_POS0:     nxt_state = ST_POS1;
                // take-b1
                ST_POS1:     nxt_state = bit_in ? ST_POS2_SET : ST_POS2_CLR;
                // take-b2
                ST_POS2_CLR: nxt_state = bit_in ? ST_POS3_SET : ST_POS3_CLR;
                ST_POS2_SET: nxt_state = ST_POS3_SET;
                // close
                ST_POS3_CLR: begin
                    nxt_state  = ST_POS0;
                    group_done = 1'b1;
                end
                ST_POS3_SET: begin
                    nxt_state  = ST_POS0;
                    group_done = 1'b1;
                    group_bad  = bit_in;
                end
                default:     nxt_state = ST_POS0;
            endcase
        end
    end

endmodule

// File: rtl/bcdchk_state_reg.sv
`timescale 1ns/1ps
module bcdchk_state_reg
    import bcdchk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_valid,
    input  chk_state_t nxt_state,
    output chk_state_t cur_state
);

    always_ff @(posedge clk) begin
        if (rst) cur_state <= ST_POS0;
        else     cur_state <= nxt_state;
    end

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bit_valid && !$past(rst)) |=> $stable(cur_state))
        else $error("state moved on an idle edge");

endmodule

// File: rtl/bcdchk_out_reg.sv
`timescale 1ns/1ps
module bcdchk_out_reg (
    input  logic clk,
    input  logic rst,
    input  logic group_done,
    input  logic group_bad,
    output logic strobe_q,
    output logic bad_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            bad_q    <= 1'b0;
        end else begin
            strobe_q <= group_done;
            bad_q    <= group_done & group_bad;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!strobe_q && !bad_q))
        else $error("outputs not cleared by reset");

    // R6
    bad_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        bad_q |-> strobe_q)
        else $error("verdict without strobe");

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_q |=> !strobe_q)
        else $error("strobe on adjacent cycles");

endmodule

// File: rtl/serial_bcd_checker.sv
`timescale 1ns/1ps
module serial_bcd_checker
    import bcdchk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_in,
    output logic digit_bad,
    output logic digit_strobe
);

    chk_state_t cur_state;
    chk_state_t nxt_state;
    logic       group_done;
    logic       group_bad;

    bcdchk_next u_next (
        .cur_state (cur_state),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .nxt_state (nxt_state),
        .group_done(group_done),
        .group_bad (group_bad)
    );

    bcdchk_state_reg u_state (
        .clk      (clk),
        .rst      (rst),
        .bit_valid(bit_valid),
        .nxt_state(nxt_state),
        .cur_state(cur_state)
    );

    bcdchk_out_reg u_out (
        .clk       (clk),
        .rst       (rst),
        .group_done(group_done),
        .group_bad (group_bad),
        .strobe_q  (digit_strobe),
        .bad_q     (digit_bad)
    );

    // R8
    strobe_home_chk: assert property (@(posedge clk) disable iff (rst)
        digit_strobe |-> (cur_state == ST_POS0))
        else $error("strobe without return to start");

    // R5
    bad_origin_chk: assert property (@(posedge clk) disable iff (rst)
        (digit_bad && !$past(rst)) |->
            ($past(cur_state) == ST_POS3_SET && $past(bit_in) && $past(bit_valid)))
        else $error("bad verdict from wrong path");

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> !digit_strobe)
        else $error("strobe after idle edge");

endmodule

// File: tb/sim_serial_bcd_checker.sv
`timescale 1ns/1ps
module sim_serial_bcd_checker;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic digit_bad;
    logic digit_strobe;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string scen = "R1";

    // behavioural reference
    int pos = 0;
    int nib = 0;
    logic exp_strobe = 1'b0;
    logic exp_bad = 1'b0;

    always #2.5 clk = ~clk;

    serial_bcd_checker u0 (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
        .digit_bad(digit_bad), .digit_strobe(digit_strobe)
    );

    task automatic cyc(input logic r, input logic v, input logic b);
        string req;
        rst = r; bit_valid = v; bit_in = b;
        @(posedge clk);
        exp_strobe = 1'b0;
        exp_bad = 1'b0;
        if (r) begin
            pos = 0; nib = 0; req = "R1";
        end else if (v) begin
            nib = nib | (int'(b) << pos);
            pos++;
            if (pos == 4) begin
                exp_strobe = 1'b1;
                exp_bad = (nib > 9);
                req = exp_bad ? "R2/R5" : "R2/R4";
                pos = 0; nib = 0;
            end else req = "R6";
        end else req = "R7";
        #1;
        checks++;
        if (digit_strobe !== exp_strobe) begin
            errors++;
            $display("FAIL %s R3 %s strobe got %b exp %b at %0t", scen, req, digit_strobe, exp_strobe, $time);
        end
        checks++;
        if (digit_bad !== exp_bad) begin
            errors++;
            $display("FAIL %s %s verdict got %b exp %b at %0t", scen, req, digit_bad, exp_bad, $time);
        end
        @(negedge clk);
    endtask

    task automatic send(input int val, input int gap);
        for (int i = 0; i < 4; i++) begin
            cyc(1'b0, 1'b1, val[i]);
            for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0, ~val[i]);
        end
    endtask

    initial begin
        @(negedge clk);
        scen = "R1";
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, 1'b1);
        // R8: back-to-back groups, all codes
        scen = "R8";
        for (int v = 0; v < 16; v++) send(v, 0);
        for (int v = 15; v >= 0; v--) send(v, 0);
        // R7: gapped groups, bit_in toggling while idle
        scen = "R7";
        for (int v = 0; v < 16; v++) send(v, (v % 3) + 1);
        // R9: reset cutting a group short
        scen = "R9";
        cyc(1'b0, 1'b1, 1'b1);
        cyc(1'b0, 1'b1, 1'b1);
        cyc(1'b1, 1'b1, 1'b1);
        send(10, 0);
        cyc(1'b0, 1'b1, 1'b1);
        cyc(1'b0, 1'b1, 1'b1);
        cyc(1'b0, 1'b1, 1'b1);
        cyc(1'b1, 1'b0, 1'b0);
        send(0, 0);
        send(9, 1);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R3 run did not end got running exp done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule